// File: doc/BRIEF.md
# Bit-Level Two-Wire Byte Store Responder

This block is the target side of a simplified two-wire serial memory with 256 bytes. A host does not run a real bus. It writes one pair of line levels (clock and data) per strobe cycle, and the responder treats each strobe as the next state of the two wires. The responder keeps the previous pair and compares every new pair against it. From that comparison it detects start and stop conditions, shifts in a command byte and then an address byte, and serializes a stored byte back to the host through a single readable data bit.

A bit counter steps the transaction. A start arms the counter at 1. Eight command bits follow, then an acknowledge slot. After that come eight address bits (write command) or eight data bits (read command). The storage is fetched when the counter reaches 17. A separate preload port fills the storage directly.

Top module: `twowire_rom_target`

## Requirements
- R1: After reset, `sdaOut` is 1, the bit counter is 0, no acknowledge is pending, and both stored line levels are high. A first strobe of clock=1, data=0 is therefore a start.
- R2: While the counter is 0 and no acknowledge is pending, every strobe other than a start leaves the counter and the acknowledge state unchanged, so no bit is captured.
- R3: A data change between two strobes whose clock level is 1 in both is a bus condition. A falling data line is a start: it clears the command, sets the counter to 1 and drops any pending acknowledge. A rising data line is a stop: it sets the counter to 0 and drops any pending acknowledge.
- R4: A bit is captured only on a clock rise (0 then 1) with the data level unchanged, and the captured bit is the data level. At counts 1 to 8 the bits fill the command MSB first. After the eighth bit an acknowledge is pending. Command bit 0 selects read (1) or write (0).
- R5: The first clock rise while an acknowledge is pending drives `sdaOut` to 0, clears the pending flag and captures no bit.
- R6: Under a write command, the next eight captured bits fill the address MSB first. On the eighth, the data register loads the byte stored at the completed address, the counter returns to 0 and an acknowledge becomes pending.
- R7: Under a read command, each of the next eight captured clock rises puts the data register MSB on `sdaOut` and shifts the register left. The address is not changed. On the eighth, the data register reloads from the same address and an acknowledge becomes pending, so a second read returns the same byte.
- R8: A clock rise in the same strobe as a data change is illegal: no bit is captured and the counter does not advance.
- R9: On a strobe where the responder neither acknowledges nor presents a read bit, `sdaOut` takes the host data level. Without a strobe, `sdaOut` holds.
- R10: A preload write stores `preData` at the 8-bit address `preAddr`. Later reads return it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| lineWe | input | 1 | Strobe: sclIn/sdaIn form the next line state |
| sclIn | input | 1 | Host clock line level |
| sdaIn | input | 1 | Host data line level |
| preWe | input | 1 | Preload write enable |
| preAddr | input | 8 | Preload address |
| preData | input | 8 | Preload byte |
| sdaOut | output | 1 | Readable data line level |

## Verification
Full random-address reads are run at addresses 0x00, 0xFF and a mid value. Each read goes write-command, address, repeated start, read-command, and it separates a correct MSB-first address and data path from bit-order or off-by-one-count faults. A rereading sequence with no new address shows that the read command leaves the address alone. An address phase with a clock rise and a data change in the same strobe shows whether an illegal event is wrongly counted, because a counted event shifts the address and moves the acknowledge. Clocking all-ones bits from idle and after a mid-command stop shows whether an acknowledge ever appears when it must not. A start from the reset state checks the reset levels.

// File: rtl/twr_pkg.sv
package twr_pkg;
  // One-cycle control strobes from the sequencer to the datapath.
  typedef struct packed {
    logic start;     // start condition: clear command
    logic cmdBit;    // shift captured bit into command
    logic addrBit;   // shift captured bit into address
    logic dataBit;   // present data MSB, shift data
    logic loadData;  // fetch storage into data register
    logic ackDrive;  // acknowledge slot: pull output low
  } twrStrobe_t;
endpackage

// File: rtl/twr_store.sv
module twr_store #(
  parameter int WORD_W = 8,
  localparam int DEPTH = 1 << WORD_W
) (
  input  logic              clk,
  input  logic              wrEn,
  input  logic [WORD_W-1:0] wrAddr,
  input  logic [WORD_W-1:0] wrData,
  input  logic [WORD_W-1:0] rdAddr,
  output logic [WORD_W-1:0] rdData
);
  logic [WORD_W-1:0] cells [DEPTH];

  always_ff @(posedge clk) begin
    if (wrEn) cells[wrAddr] <= wrData;
  end

  assign rdData = cells[rdAddr];
endmodule

// File: rtl/twr_ctl.sv
module twr_ctl
  import twr_pkg::*;
#(
  parameter int WORD_W = 8,
  parameter int TICK_W = $clog2(2 * WORD_W + 2)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              lineWe,
  input  logic              sclIn,
  input  logic              sdaIn,
  input  logic              rdCmd,
  output twrStrobe_t        strobe,
  output logic [TICK_W-1:0] tickNow,
  output logic              ackPend
);
  localparam logic [TICK_W-1:0] CMD_END = TICK_W'(WORD_W + 1);
  localparam logic [TICK_W-1:0] PAY_END = TICK_W'(2 * WORD_W + 1);
  localparam logic [TICK_W-1:0] ONE     = TICK_W'(1);

  logic prevScl, prevSda;
  logic busCond, sclRise, waiting, active;
  logic ackCyc, bitOk, cmdBit, payBit, stopEv;
  logic [TICK_W-1:0] tickInc;

  always_comb begin
    busCond = prevScl & sclIn & (prevSda ^ sdaIn);
    sclRise = ~prevScl & sclIn;
    waiting = (tickNow == '0) & ~ackPend;
    active  = lineWe & ~busCond & ~waiting & sclRise;
    ackCyc  = active & ackPend;
    bitOk   = active & ~ackPend & (prevSda == sdaIn);
    cmdBit  = bitOk & (tickNow < CMD_END);
    payBit  = bitOk & (tickNow >= CMD_END) & (tickNow < PAY_END);
    tickInc = tickNow + ONE;
    stopEv  = lineWe & busCond & sdaIn;

    strobe.start    = lineWe & busCond & ~sdaIn;
    strobe.cmdBit   = cmdBit;
    strobe.addrBit  = payBit & ~rdCmd;
    strobe.dataBit  = payBit & rdCmd;
    strobe.loadData = payBit & (tickInc == PAY_END);
    strobe.ackDrive = ackCyc;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      prevScl <= 1'b1;
      prevSda <= 1'b1;
      tickNow <= '0;
      ackPend <= 1'b0;
    end else begin
      if (lineWe) begin
        prevScl <= sclIn;
        prevSda <= sdaIn;
      end
      if (strobe.start) begin
        tickNow <= ONE;
        ackPend <= 1'b0;
      end else if (stopEv) begin
        tickNow <= '0;
        ackPend <= 1'b0;
      end else if (ackCyc) begin
        ackPend <= 1'b0;
      end else if (cmdBit) begin
        tickNow <= tickInc;
        if (tickInc == CMD_END) ackPend <= 1'b1;
      end else if (payBit) begin
        if (tickInc == PAY_END) begin
          tickNow <= '0;
          ackPend <= 1'b1;
        end else begin
          tickNow <= tickInc;
        end
      end
    end
  end
endmodule

// File: rtl/twr_datapath.sv
module twr_datapath
  import twr_pkg::*;
#(
  parameter int WORD_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              lineWe,
  input  logic              sdaIn,
  input  twrStrobe_t        strobe,
  input  logic [WORD_W-1:0] rdData,
  output logic [WORD_W-1:0] rdAddr,
  output logic [WORD_W-1:0] cmdByte,
  output logic              sdaOut
);
  logic [WORD_W-1:0] addrReg, addrNext, dataReg;

  always_comb begin
    addrNext = {addrReg[WORD_W-2:0], sdaIn};
    rdAddr   = strobe.addrBit ? addrNext : addrReg;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cmdByte <= '0;
      addrReg <= '0;
      dataReg <= '0;
      sdaOut  <= 1'b1;
    end else begin
      if (strobe.start)       cmdByte <= '0;
      else if (strobe.cmdBit) cmdByte <= {cmdByte[WORD_W-2:0], sdaIn};

      if (strobe.addrBit) addrReg <= addrNext;

      if (strobe.loadData)     dataReg <= rdData;
      else if (strobe.dataBit) dataReg <= {dataReg[WORD_W-2:0], 1'b0};

      if (lineWe) begin
        if (strobe.ackDrive)     sdaOut <= 1'b0;
        else if (strobe.dataBit) sdaOut <= dataReg[WORD_W-1];
        else                     sdaOut <= sdaIn;
      end
    end
  end
endmodule

// File: rtl/twowire_rom_target.sv
module twowire_rom_target
  import twr_pkg::*;
#(
  parameter int WORD_W = 8,
  localparam int TICK_W = $clog2(2 * WORD_W + 2)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              lineWe,
  input  logic              sclIn,
  input  logic              sdaIn,
  input  logic              preWe,
  input  logic [WORD_W-1:0] preAddr,
  input  logic [WORD_W-1:0] preData,
  output logic              sdaOut
);
  twrStrobe_t        strobe;
  logic [TICK_W-1:0] tickNow;
  logic              ackPend;
  logic [WORD_W-1:0] cmdByte, rdAddr, rdData;
  logic              rdCmd;

  assign rdCmd = cmdByte[0];

  twr_ctl #(.WORD_W(WORD_W), .TICK_W(TICK_W)) uCtl (
    .clk(clk), .rstN(rstN), .lineWe(lineWe), .sclIn(sclIn), .sdaIn(sdaIn),
    .rdCmd(rdCmd), .strobe(strobe), .tickNow(tickNow), .ackPend(ackPend)
  );

  twr_datapath #(.WORD_W(WORD_W)) uDp (
    .clk(clk), .rstN(rstN), .lineWe(lineWe), .sdaIn(sdaIn), .strobe(strobe),
    .rdData(rdData), .rdAddr(rdAddr), .cmdByte(cmdByte), .sdaOut(sdaOut)
  );

  twr_store #(.WORD_W(WORD_W)) uStore (
    .clk(clk), .wrEn(preWe), .wrAddr(preAddr), .wrData(preData),
    .rdAddr(rdAddr), .rdData(rdData)
  );
endmodule

// File: rtl/twr_checker.sv
module twr_checker
  import twr_pkg::*;
#(
  parameter int WORD_W = 8,
  parameter int TICK_W = 5
) (
  input logic              clk,
  input logic              rstN,
  input logic              lineWe,
  input logic              sdaIn,
  input logic              sdaOut,
  input twrStrobe_t        strobe,
  input logic [TICK_W-1:0] tickNow,
  input logic              ackPend,
  input logic [WORD_W-1:0] cmdByte
);
  localparam logic [TICK_W-1:0] PAY_END = TICK_W'(2 * WORD_W + 1);

  // R5
  ack_low_chk: assert property (@(posedge clk) disable iff (!rstN)
    strobe.ackDrive |=> !sdaOut);

  // R9
  echo_chk: assert property (@(posedge clk) disable iff (!rstN)
    (lineWe && !strobe.ackDrive && !strobe.dataBit) |=> (sdaOut == $past(sdaIn)));

  // R9
  hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !lineWe |=> $stable(sdaOut));

  // R3
  start_chk: assert property (@(posedge clk) disable iff (!rstN)
    strobe.start |=> (tickNow == TICK_W'(1) && !ackPend && cmdByte == '0));

  // R2
  idle_chk: assert property (@(posedge clk) disable iff (!rstN)
    (lineWe && tickNow == '0 && !ackPend && !strobe.start) |=> (tickNow == '0 && !ackPend));

  // R6
  load_chk: assert property (@(posedge clk) disable iff (!rstN)
    strobe.loadData |=> (ackPend && tickNow == '0));

  // R4
  bound_chk: assert property (@(posedge clk) disable iff (!rstN)
    tickNow < PAY_END);

  // R8
  excl_chk: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({strobe.start, strobe.cmdBit, strobe.addrBit, strobe.dataBit, strobe.ackDrive}));
endmodule

bind twowire_rom_target twr_checker #(.WORD_W(WORD_W), .TICK_W(TICK_W)) uChk (
  .clk(clk), .rstN(rstN), .lineWe(lineWe), .sdaIn(sdaIn), .sdaOut(sdaOut),
  .strobe(strobe), .tickNow(tickNow), .ackPend(ackPend), .cmdByte(cmdByte)
);

// File: tb/twowire_rom_target_test.sv
module twowire_rom_target_test;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       lineWe = 1'b0, sclIn = 1'b1, sdaIn = 1'b1;
  logic       preWe = 1'b0;
  logic [7:0] preAddr = '0, preData = '0;
  logic       sdaOut;

  int checks = 0;
  int failures = 0;
  bit finished = 1'b0;
  logic [7:0] model [256];

  always #(CLK_PERIOD / 2) clk = ~clk;

  twowire_rom_target uut (
    .clk(clk), .rstN(rstN), .lineWe(lineWe), .sclIn(sclIn), .sdaIn(sdaIn),
    .preWe(preWe), .preAddr(preAddr), .preData(preData), .sdaOut(sdaOut)
  );

  task automatic chk(input string req, input string what, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic doReset();
    @(negedge clk);
    rstN = 1'b0; lineWe = 1'b0; sclIn = 1'b1; sdaIn = 1'b1;
    repeat (2) @(negedge clk);
    rstN = 1'b1;
  endtask

  task automatic drive(input logic c, input logic d);
    @(negedge clk);
    sclIn = c; sdaIn = d; lineWe = 1'b1;
    @(negedge clk);
    lineWe = 1'b0;
  endtask

  task automatic sendBit(input logic b);
    drive(1'b0, b);
    drive(1'b1, b);
  endtask

  task automatic sendByte(input logic [7:0] v);
    for (int i = 7; i >= 0; i--) sendBit(v[i]);
  endtask

  task automatic startCond();
    drive(1'b0, 1'b1); drive(1'b1, 1'b1); drive(1'b1, 1'b0);
  endtask

  task automatic stopCond();
    drive(1'b0, 1'b0); drive(1'b1, 1'b0); drive(1'b1, 1'b1);
  endtask

  task automatic ackSlot(input string req);
    drive(1'b0, 1'b1); drive(1'b1, 1'b1);
    chk(req, "ack slot sdaOut", {7'd0, sdaOut}, 8'd0);
  endtask

  task automatic readBits(output logic [7:0] v);
    for (int i = 7; i >= 0; i--) begin
      drive(1'b0, 1'b1); drive(1'b1, 1'b1);
      v[i] = sdaOut;
    end
  endtask

  task automatic preload(input logic [7:0] a, input logic [7:0] d);
    @(negedge clk);
    preWe = 1'b1; preAddr = a; preData = d;
    @(negedge clk);
    preWe = 1'b0;
    model[a] = d;
  endtask

  // Full random read: write command, address, repeated start, read command.
  task automatic testReadAt(input logic [7:0] a);
    logic [7:0] got;
    startCond();
    sendByte(8'hA0); ackSlot("R4");
    sendByte(a);     ackSlot("R6");
    startCond();
    sendByte(8'hA1); ackSlot("R4");
    readBits(got);
    chk("R7", $sformatf("read byte at %h", a), got, model[a]);
    ackSlot("R7");
    stopCond();
  endtask

  task automatic testResetState();
    doReset();
    chk("R1", "sdaOut after reset", {7'd0, sdaOut}, 8'd1);
    // Stored levels are high: a single (1,0) strobe is a start.
    drive(1'b1, 1'b0);
    sendByte(8'hA0);
    ackSlot("R1");
    stopCond();
  endtask

  task automatic testIdleIgnored();
    doReset();
    for (int i = 0; i < 10; i++) begin
      sendBit(1'b1);
      chk("R2", "idle clock rise echoes host", {7'd0, sdaOut}, 8'd1);
    end
  endtask

  task automatic testStopClears();
    startCond();
    sendBit(1'b1); sendBit(1'b0); sendBit(1'b1);
    stopCond();
    for (int i = 0; i < 12; i++) begin
      sendBit(1'b1);
      chk("R3", "after stop no acknowledge", {7'd0, sdaOut}, 8'd1);
    end
  endtask

  task automatic testReread(input logic [7:0] a);
    logic [7:0] got;
    testReadAt(a);
    startCond();
    sendByte(8'hA1); ackSlot("R4");
    readBits(got);
    chk("R7", "second read keeps address", got, model[a]);
    ackSlot("R7");
    stopCond();
  endtask

  task automatic testGlitch();
    logic [7:0] got;
    startCond();
    sendByte(8'hA0); ackSlot("R4");
    sendBit(1'b1); sendBit(1'b1); sendBit(1'b0);
    drive(1'b0, 1'b1);
    drive(1'b1, 1'b0);  // clock rise with data change: illegal
    chk("R9", "echo on illegal event", {7'd0, sdaOut}, 8'd0);
    sendBit(1'b0); sendBit(1'b0); sendBit(1'b1); sendBit(1'b0); sendBit(1'b1);
    ackSlot("R8");
    startCond();
    sendByte(8'hA1); ackSlot("R8");
    readBits(got);
    chk("R8", "address unaffected by illegal event", got, model[8'hC5]);
    ackSlot("R8");
    stopCond();
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      failures++;
      $display("FAIL R1 watchdog actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    testIdleIgnored();
    testResetState();
    for (int a = 0; a < 256; a++) preload(8'(a), 8'(a * 37 + 11));
    testReadAt(8'h00);
    testReadAt(8'hFF);
    testReadAt(8'h5C);
    preload(8'h5C, 8'h96);
    testReadAt(8'h5C);  // R10 preload overwrite
    chk("R10", "model overwrite", model[8'h5C], 8'h96);
    testReread(8'h33);
    testGlitch();
    testStopClears();
    finished = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule